// File: doc/BRIEF.md
# Four-Bit Microcontroller I/O Port

This block is one general-purpose I/O port of a small microcontroller. It has four pins. Pins 0 to 2 are bidirectional, and each one has a direction bit, an output-latch bit and an analog-select bit. Pin 3 can only be an input. Pin 3 also serves as the active-low external reset line. A configuration input chooses which of these two roles pin 3 has. The pad inputs are raw, so every pin passes through a two-flop synchronizer before any read or reset logic sees it.

Software reaches the port through a small register bus. A write happens on a single-cycle strobe. Read data is combinational from the address.

The register addresses are:
- 0: port. A read returns the synchronized pin levels. A write loads the output latch.
- 1: output latch.
- 2: direction.
- 3: analog select.

A direction bit of 1 makes the pin an input, with its driver off. A direction bit of 0 makes the pin drive its latch bit.

A build-time parameter selects a reduced-pin variant. In that variant every read of address 0 returns 0x00. The bus has no stream data path, so there is no valid/ready handshake. Every pin is plain, and the bus accepts a write in the cycle its strobe is high.

Top module: `gpio4_port`

## Requirements
- R1: After reset the block is in this state:
  - direction bits 2:0 read 1 and `pin_oe` is 000;
  - the output latch reads 0x00;
  - analog select bits 2:0 read 1;
  - the upper direction bits 7:4 read 0;
  - bits 2:0 of a port read (address 0) are 0.
- R2: For each pin i in 0..2, `pin_oe[i]` is the inverse of direction bit i. The cycle after a write to address 2, `pin_oe` equals the inverse of `wdata[2:0]`.
- R3: A pin whose analog-select bit (address 3, bits 2:0) is 1 reads as 0 in bits 2:0 of a port read, whatever its level. The pin's driver still follows its direction bit.
- R4: A read of address 1 returns the latch value in bits 2:0 and 0 in bits 7:3, whatever the pin levels are. `pin_out` always equals the latch.
- R5: A write to address 0 loads `wdata[2:0]` into the output latch, exactly as a write to address 1 does. The new value shows on `pin_out` in the next cycle.
- R6: When `rst_pin_en` is 0, bit 3 of a port read is the synchronized level of pin 3. When `rst_pin_en` is 1, bit 3 reads 0, and `ext_reset_req` is high while the synchronized pin 3 is low. `ext_reset_req` is 0 whenever `rst_pin_en` is 0.
- R7: Direction bits 7:4 are plain storage that reads back what was written. Direction bit 3 always reads 0.
- R8: A change on `pin_in` appears in a port read two clock edges later. Port read bits 7:4 are always 0.
- R9: With `FULL_PORT` = 0, every read of address 0 returns 0x00. All other registers and pins behave as in the full variant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | 2 | Register address: 0 port, 1 latch, 2 direction, 3 analog select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| rst_pin_en | input | 1 | 1: pin 3 is the external reset input; 0: pin 3 is a digital input |
| pin_in | input | 4 | Raw pad input levels, pins 3..0 |
| pin_out | output | 3 | Drive values for pins 2..0 |
| pin_oe | output | 3 | Output enables for pins 2..0 (1 = driving) |
| ext_reset_req | output | 1 | Active-high reset request from pin 3 in reset mode |

## Verification
The case that is hardest to reach from the ports has two parts. The first is a pin configured as an output whose pad level differs from its latch. The second is a pin that is an analog input and is also driving. To set these up, the bench writes the direction and analog registers into mixed settings. It then drives `pin_in` with values that oppose the latch. This separates latch reads, port reads and driver enables from one another. The bench also toggles `rst_pin_en` while pin 3 is moving, so that the masking of bit 3 and the reset request are each checked against the synchronizer delay.

// File: rtl/gpio4_pkg.sv
package gpio4_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PORT = 2'd0,
    REG_LATCH = 2'd1,
    REG_DIR = 2'd2,
    REG_ANSEL = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/gpio4_sync.sv
module gpio4_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio4_regs.sv
module gpio4_regs
  import gpio4_pkg::*;
#(
  parameter int NUM_IO = 3,
  parameter int RSV_W  = 4,
  parameter int BUS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_addr_e         addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [NUM_IO-1:0] dir_q,
  output logic [NUM_IO-1:0] lat_q,
  output logic [NUM_IO-1:0] ana_q,
  output logic [RSV_W-1:0]  rsv_q
);
  localparam int RSV_LSB = BUS_W - RSV_W;

  logic lat_we, dir_we, ana_we;

  always_comb begin
    lat_we = wr_en && ((addr == REG_PORT) || (addr == REG_LATCH));
    dir_we = wr_en && (addr == REG_DIR);
    ana_we = wr_en && (addr == REG_ANSEL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      lat_q <= '0;
      ana_q <= '1;
      rsv_q <= '0;
    end else begin
      if (lat_we) lat_q <= wdata[NUM_IO-1:0];
      if (dir_we) begin
        dir_q <= wdata[NUM_IO-1:0];
        rsv_q <= wdata[RSV_LSB +: RSV_W];
      end
      if (ana_we) ana_q <= wdata[NUM_IO-1:0];
    end
  end
endmodule

// File: rtl/gpio4_rdmux.sv
module gpio4_rdmux
  import gpio4_pkg::*;
#(
  parameter int NUM_IO    = 3,
  parameter int RSV_W     = 4,
  parameter int BUS_W     = 8,
  parameter bit FULL_PORT = 1'b1
) (
  input  reg_addr_e         addr,
  input  logic [NUM_IO:0]   pin_sync,
  input  logic              rst_pin_en,
  input  logic [NUM_IO-1:0] dir_q,
  input  logic [NUM_IO-1:0] lat_q,
  input  logic [NUM_IO-1:0] ana_q,
  input  logic [RSV_W-1:0]  rsv_q,
  output logic [BUS_W-1:0]  rdata
);
  localparam int RSV_LSB = BUS_W - RSV_W;

  logic [BUS_W-1:0] port_val;

  genvar i;
  generate
    for (i = 0; i < NUM_IO; i++) begin : g_bit
      assign port_val[i] = FULL_PORT && !ana_q[i] && pin_sync[i];
    end
    for (i = NUM_IO + 1; i < BUS_W; i++) begin : g_hi
      assign port_val[i] = 1'b0;
    end
  endgenerate
  assign port_val[NUM_IO] = FULL_PORT && !rst_pin_en && pin_sync[NUM_IO];

  always_comb begin
    rdata = '0;
    unique case (addr)
      REG_PORT:  rdata = port_val;
      REG_LATCH: rdata[NUM_IO-1:0] = lat_q;
      REG_DIR: begin
        rdata[NUM_IO-1:0] = dir_q;
        rdata[RSV_LSB +: RSV_W] = rsv_q;
      end
      REG_ANSEL: rdata[NUM_IO-1:0] = ana_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio4_port.sv
module gpio4_port
  import gpio4_pkg::*;
#(
  parameter int NUM_IO      = 3,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit FULL_PORT   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  input  logic              rst_pin_en,
  input  logic [NUM_IO:0]   pin_in,
  output logic [NUM_IO-1:0] pin_out,
  output logic [NUM_IO-1:0] pin_oe,
  output logic              ext_reset_req
);
  localparam int NUM_PINS = NUM_IO + 1;
  localparam int RSV_W    = BUS_W - NUM_PINS;

  reg_addr_e         addr_e;
  logic [NUM_IO:0]   pin_sync;
  logic [NUM_IO-1:0] dir_q, lat_q, ana_q;
  logic [RSV_W-1:0]  rsv_q;

  assign addr_e = reg_addr_e'(addr);

  gpio4_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pin_in), .q_out(pin_sync)
  );

  gpio4_regs #(.NUM_IO(NUM_IO), .RSV_W(RSV_W), .BUS_W(BUS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr_e), .wdata(wdata),
    .dir_q(dir_q), .lat_q(lat_q), .ana_q(ana_q), .rsv_q(rsv_q)
  );

  gpio4_rdmux #(.NUM_IO(NUM_IO), .RSV_W(RSV_W), .BUS_W(BUS_W),
                .FULL_PORT(FULL_PORT)) u_rdmux (
    .addr(addr_e), .pin_sync(pin_sync), .rst_pin_en(rst_pin_en),
    .dir_q(dir_q), .lat_q(lat_q), .ana_q(ana_q), .rsv_q(rsv_q),
    .rdata(rdata)
  );

  assign pin_out       = lat_q;
  assign pin_oe        = ~dir_q;
  assign ext_reset_req = rst_pin_en && !pin_sync[NUM_IO];
endmodule

// File: rtl/gpio4_port_chk.sv
module gpio4_port_chk #(
  parameter int NUM_IO = 3,
  parameter int BUS_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic [BUS_W-1:0]  wdata,
  input logic [BUS_W-1:0]  rdata,
  input logic              rst_pin_en,
  input logic [NUM_IO-1:0] pin_out,
  input logic [NUM_IO-1:0] pin_oe,
  input logic              ext_reset_req,
  input logic [NUM_IO-1:0] ana_q
);
  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2) |=> (pin_oe == ~$past(wdata[NUM_IO-1:0]))); // R2

  AST_PORT_WR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> (pin_out == $past(wdata[NUM_IO-1:0]))); // R5

  AST_LATCH_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1) |=> (pin_out == $past(wdata[NUM_IO-1:0]))); // R4

  AST_LATCH_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd1) |-> (rdata == {{(BUS_W-NUM_IO){1'b0}}, pin_out})); // R4

  AST_ANALOG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd0) |-> ((rdata[NUM_IO-1:0] & ana_q) == '0)); // R3

  AST_BIT3_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd0 && rst_pin_en) |-> (rdata[NUM_IO] == 1'b0)); // R6

  AST_RESET_REQ_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    ext_reset_req |-> rst_pin_en); // R6

  AST_PORT_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd0) |-> (rdata[BUS_W-1:NUM_IO+1] == '0)); // R8
endmodule

bind gpio4_port gpio4_port_chk #(.NUM_IO(NUM_IO), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .rst_pin_en(rst_pin_en), .pin_out(pin_out),
  .pin_oe(pin_oe), .ext_reset_req(ext_reset_req), .ana_q(ana_q)
);

// File: tb/sim_gpio4_port.sv
`timescale 1ns/1ps
module sim_gpio4_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic       rst_pin_en = 1'b0;
  logic [3:0] pin_in = 4'd0;
  logic [7:0] rdata, rdata_r;
  logic [2:0] pin_out, pin_oe, pin_out_r, pin_oe_r;
  logic       ext_reset_req, ext_reset_req_r;

  int checks = 0;
  int errors = 0;

  // behavioural model state
  int m_dir = 7, m_lat = 0, m_ana = 7, m_rsv = 0;
  int m_s1 = 0, m_s2 = 0;

  always #5 clk = ~clk;

  gpio4_port u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rst_pin_en(rst_pin_en), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .ext_reset_req(ext_reset_req)
  );

  gpio4_port #(.FULL_PORT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata_r), .rst_pin_en(rst_pin_en), .pin_in(pin_in),
    .pin_out(pin_out_r), .pin_oe(pin_oe_r), .ext_reset_req(ext_reset_req_r)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = 7; m_lat = 0; m_ana = 7; m_rsv = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      m_s2 = m_s1;
      m_s1 = int'(pin_in);
      if (wr_en) begin
        case (addr)
          2'd0, 2'd1: m_lat = wdata & 7;
          2'd2: begin m_dir = wdata & 7; m_rsv = (wdata >> 4) & 15; end
          default: m_ana = wdata & 7;
        endcase
      end
    end
  end

  function automatic int exp_port();
    int v = 0;
    for (int i = 0; i < 3; i++)
      if (((m_ana >> i) & 1) == 0 && ((m_s2 >> i) & 1) == 1) v += (1 << i);
    if (!rst_pin_en && ((m_s2 >> 3) & 1) == 1) v += 8;
    return v;
  endfunction

  function automatic int exp_rd(bit full);
    case (addr)
      2'd0: return full ? exp_port() : 0;
      2'd1: return m_lat;
      2'd2: return m_dir + (m_rsv << 4);
      default: return m_ana;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string rd_tag();
    case (addr)
      2'd0: return "R8";
      2'd1: return "R4";
      2'd2: return "R7";
      default: return "R3";
    endcase
  endfunction

  // compare all outputs against the model, away from the clock edge
  task automatic compare();
    int ereq;
    ereq = (rst_pin_en && ((m_s2 >> 3) & 1) == 0) ? 1 : 0;
    chk(rd_tag(), int'(rdata), exp_rd(1'b1));
    chk(addr == 2'd0 ? "R9" : rd_tag(), int'(rdata_r), exp_rd(1'b0));
    chk("R2", int'(pin_oe), (~m_dir) & 7);
    chk("R5", int'(pin_out), m_lat);
    chk("R6", int'(ext_reset_req), ereq);
    chk("R9", int'({pin_oe_r, pin_out_r}), int'({pin_oe, pin_out}));
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    compare();
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd_at(logic [1:0] a);
    addr = a;
    #1;
    compare();
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rst_n = 1'b1;
    // R1: reset state
    addr = 2'd2; #1; chk("R1", int'(rdata), 8'h07);
    chk("R1", int'(pin_oe), 0);
    addr = 2'd1; #1; chk("R1", int'(rdata), 0);
    addr = 2'd3; #1; chk("R1", int'(rdata), 7);
    pin_in = 4'h7;
    step(); step();
    addr = 2'd0; #1; chk("R1", int'(rdata[2:0]), 0);

    // R3: analog pins read zero, driver follows direction
    bus_wr(2'd2, 8'h05);
    rd_at(2'd0);
    chk("R3", int'(pin_oe), 2);
    bus_wr(2'd3, 8'h02);
    rd_at(2'd0);
    chk("R3", int'(rdata[2:0]), 5);
    chk("R3", int'(pin_oe), 2);

    // R4/R5: latch vs pin level, port write loads latch
    bus_wr(2'd0, 8'h05);
    pin_in = 4'h2;
    step(); step();
    rd_at(2'd1);
    chk("R4", int'(rdata), 5);
    bus_wr(2'd1, 8'hFA);
    chk("R5", int'(pin_out), 2);

    // R7: reserved direction bits
    bus_wr(2'd2, 8'hAF);
    rd_at(2'd2);
    chk("R7", int'(rdata), 8'hA7);

    // R8: synchronizer latency
    bus_wr(2'd3, 8'h00);
    rst_pin_en = 1'b0;
    addr = 2'd0;
    pin_in = 4'h0;
    step(); step();
    pin_in = 4'hF;
    step(); chk("R8", int'(rdata), 0);
    step(); chk("R8", int'(rdata), 8'h0F);

    // R6: pin 3 as reset input
    rst_pin_en = 1'b1; #1;
    chk("R6", int'(rdata[3]), 0);
    chk("R6", int'(ext_reset_req), 0);
    pin_in = 4'h0;
    step(); step();
    chk("R6", int'(ext_reset_req), 1);
    rst_pin_en = 1'b0; #1;
    chk("R6", int'(ext_reset_req), 0);
    // R9: reduced variant port read
    chk("R9", int'(rdata_r), 0);

    // mixed random traffic compared every cycle
    for (int n = 0; n < 2000; n++) begin
      wr_en = ($urandom % 3) == 0;
      addr = 2'($urandom);
      wdata = 8'($urandom);
      if (($urandom % 4) == 0) pin_in = 4'($urandom);
      if (($urandom % 16) == 0) rst_pin_en = ~rst_pin_en;
      step();
    end
    wr_en = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule